// File: doc/BRIEF.md
# Serial Port Register Front-End

This block sits between a 32-bit register bus and the line side of a small serial port. It decodes four word registers: receive data, transmit data, status and control. It also buffers received bytes in an eight-entry FIFO and hands transmitted bytes to a byte-stream output. The bit shifter and baud logic sit outside this block. They connect through a valid/ready byte input for received data and a valid/ready byte output for data to send.

Software learns the port state from the status word and clears either direction through the control register. It can take a level interrupt, gated by a control enable. The interrupt-pending flag is raised by a non-empty receive buffer and by any transmit write. A status read clears it only when nothing is left to receive. Reading the receive register pops the oldest byte.

Top module: `serial_regfront`

## Requirements
- R1: The register index is byte address bits [3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. Any address with a nonzero bit above bit 3 reads as zero, and a write to it changes nothing.
- R2: Status layout: bit 0 means at least one received byte is held. Bit 1 means eight are held. Bit 2 means no transmit byte is waiting, and bit 3 means one is waiting. Bits 6 and 7 and bits 31:8 read zero. After reset the status reads 0x04.
- R3: Received bytes leave in arrival order, and up to eight are held. A read of index 0 returns the oldest byte in bits [7:0], with zero above, and removes it. A read while the buffer is empty returns zero and changes no state.
- R4: `rx_ready` is high exactly while fewer than eight bytes are held. A byte offered while eight are held is discarded and the held contents are unchanged.
- R5: A discarded byte sets status bit 5. The bit stays set until a status read, which still returns it as 1 and clears it afterwards.
- R6: A control write stores all 32 bits, and index 3 reads them back. If bit 1 of the written value is set, the receive buffer is emptied at that edge.
- R7: A write to index 1 presents bits [7:0] on `tx_data` with `tx_valid` high from the next cycle until a cycle with `tx_ready` high. A second write before that replaces the waiting byte.
- R8: A control write with bit 0 set drops any waiting transmit byte, so `tx_valid` is low in the next cycle.
- R9: Status bit 4 (pending) is set when the receive buffer is non-empty and when index 1 is written. A status read clears it only if the buffer was empty during that read.
- R10: `irq` is high exactly when status bit 4 and control bit 4 are both set.
- R11: Index 1 reads as zero. Writes to index 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive buffer has room |
| tx_data | output | 8 | Byte to send |
| tx_valid | output | 1 | Byte to send is waiting |
| tx_ready | input | 1 | Line side takes the byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the buffer, then offers a ninth byte. A buffer that accepted it would corrupt the order, and a missing overrun flag would hide the loss. It drains across the pointer wrap, where a wrong wrap returns stale bytes. It reads the buffer while empty, where a faulty pop would drive the count negative. It checks that a status read leaves pending set while bytes remain, and that it clears the overrun flag. It also checks transmit replacement, the transmit flush, and that ignored writes to status and unmapped addresses leave control untouched.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int IDX_RXD  = 0;
    localparam int IDX_TXD  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTRL = 3;

    localparam int CT_TXCLR = 0;
    localparam int CT_RXCLR = 1;
    localparam int CT_IRQEN = 4;

    typedef struct packed {
        logic [31:0] ctrl;
        logic        pend;
        logic        ovr;
    } regs_t;
endpackage

// File: rtl/srf_rx_fifo.sv
module srf_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             will_hold
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fstate_t;

    fstate_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = wrap_inc(s_q.wr);
            if (do_pop)  s_d.rd = wrap_inc(s_q.rd);
            if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
            else if (do_pop && !do_push) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 mem_q[i] <= '0;
            else if (do_push && s_q.wr == PTR_W'(i))    mem_q[i] <= push_data;
        end
    end

    assign head      = mem_q[s_q.rd];
    assign count     = s_q.cnt;
    assign will_hold = (s_d.cnt != '0);
endmodule

// File: rtl/srf_tx_hold.sv
module srf_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          flush,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } hstate_t;

    hstate_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (h_q.valid && out_ready) h_d.valid = 1'b0;
        if (load) begin
            h_d.valid = 1'b1;
            h_d.data  = load_data;
        end
        if (flush) h_d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign out_valid = h_q.valid;
    assign out_data  = h_q.data;
endmodule

// File: rtl/serial_regfront.sv
module serial_regfront #(
    parameter int ADDR_W   = 5,
    parameter int RX_DEPTH = 8,
    localparam int IDX_W   = ADDR_W - 2,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);
    import srf_pkg::*;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lo;
    logic             rd_rx, rd_stat, wr_tx, wr_ctrl;
    logic             rx_clr, tx_clr, drop;
    logic [7:0]       fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_full, fifo_empty, fifo_will_hold;
    logic [31:0]      stat_word;
    logic             pend_flag, ovr_flag;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign unused_lo = bus_addr[1:0];

    assign rd_rx   = bus_sel && !bus_wr && (idx == IDX_W'(IDX_RXD));
    assign rd_stat = bus_sel && !bus_wr && (idx == IDX_W'(IDX_STAT));
    assign wr_tx   = bus_sel &&  bus_wr && (idx == IDX_W'(IDX_TXD));
    assign wr_ctrl = bus_sel &&  bus_wr && (idx == IDX_W'(IDX_CTRL));
    assign rx_clr  = wr_ctrl && bus_wdata[CT_RXCLR];
    assign tx_clr  = wr_ctrl && bus_wdata[CT_TXCLR];
    assign drop    = rx_valid && fifo_full;

    srf_rx_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (rd_rx),
        .flush     (rx_clr),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .will_hold (fifo_will_hold)
    );

    srf_tx_hold #(.DW(8)) u_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_tx),
        .load_data (bus_wdata[7:0]),
        .flush     (tx_clr),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data)
    );

    always_comb begin
        stat_word    = '0;
        stat_word[0] = !fifo_empty;
        stat_word[1] = fifo_full;
        stat_word[2] = !tx_valid;
        stat_word[3] = tx_valid;
        stat_word[4] = r_q.pend;
        stat_word[5] = r_q.ovr;
    end

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = bus_wdata;
        if (rd_stat) r_d.ovr = 1'b0;
        if (drop)    r_d.ovr = 1'b1;
        if (rd_stat && fifo_empty) r_d.pend = 1'b0;
        if (wr_tx || fifo_will_hold) r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (idx)
                IDX_W'(IDX_RXD):  bus_rdata = fifo_empty ? 32'd0 : {24'd0, fifo_head};
                IDX_W'(IDX_STAT): bus_rdata = stat_word;
                IDX_W'(IDX_CTRL): bus_rdata = r_q.ctrl;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign rx_ready  = !fifo_full;
    assign pend_flag = r_q.pend;
    assign ovr_flag  = r_q.ovr;
    assign irq       = r_q.pend && r_q.ctrl[CT_IRQEN];
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
    parameter int ADDR_W   = 5,
    parameter int RX_DEPTH = 8,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              irq,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              pend_flag,
    input logic              ovr_flag
);
    logic is_rx_rd, is_tx_wr, is_ctrl_wr, is_stat_rd;
    assign is_rx_rd   = bus_sel && !bus_wr && bus_addr == ADDR_W'(0);
    assign is_tx_wr   = bus_sel &&  bus_wr && bus_addr == ADDR_W'(4);
    assign is_ctrl_wr = bus_sel &&  bus_wr && bus_addr == ADDR_W'(12);
    assign is_stat_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(8);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(RX_DEPTH)); // R3
    AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CNT_W'(RX_DEPTH)) |-> !rx_ready); // R4
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rx_rd && fifo_count != '0 && !rx_valid) |=> fifo_count == $past(fifo_count) - 1'b1); // R3
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> ovr_flag); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && bus_wdata[1]) |=> fifo_count == '0); // R6
    AST_TX_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        is_tx_wr |=> (tx_valid && tx_data == $past(bus_wdata[7:0]))); // R7
    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && bus_wdata[0]) |=> !tx_valid); // R8
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stat_rd && fifo_count != '0) |=> pend_flag); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_flag); // R10
endmodule

bind serial_regfront srf_checker #(.ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH)) u_srf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .irq        (irq),
    .fifo_count (fifo_count),
    .pend_flag  (pend_flag),
    .ovr_flag   (ovr_flag)
);

// File: tb/test_serial_regfront.sv
module test_serial_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int NVEC = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        rx_data = '0;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    serial_regfront #(.ADDR_W(ADDR_W), .RX_DEPTH(8)) i_serial_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {is_read, tag, addr, data}: data is write value or expected read value
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b1, 8'd2,  8'h08, 32'h0000_0004},  // R2 reset status
        {1'b0, 8'd6,  8'h0C, 32'h0000_0010},
        {1'b1, 8'd6,  8'h0C, 32'h0000_0010},  // R6 control readback
        {1'b0, 8'd7,  8'h04, 32'h0000_01A5},
        {1'b1, 8'd11, 8'h04, 32'h0000_0000},  // R11 tx index reads zero
        {1'b0, 8'd11, 8'h08, 32'h0000_00FF},  // R11 status write ignored
        {1'b1, 8'd9,  8'h08, 32'h0000_0018},  // R9 pending after tx write
        {1'b1, 8'd9,  8'h08, 32'h0000_0008},  // R9 cleared by read
        {1'b0, 8'd1,  8'h10, 32'h0000_FFFF},
        {1'b1, 8'd1,  8'h10, 32'h0000_0000},  // R1 unmapped reads zero
        {1'b1, 8'd1,  8'h0C, 32'h0000_0010},  // R1 unmapped write no effect
        {1'b0, 8'd8,  8'h0C, 32'h0000_0011},
        {1'b1, 8'd8,  8'h08, 32'h0000_0004}   // R8 tx byte dropped
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic rd, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rdv);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = !rd; bus_addr = a[ADDR_W-1:0]; bus_wdata = wd;
        #1 rdv = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] dummy;
        bus(1'b0, a, wd, dummy);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus(1'b1, a, 32'd0, v);
        chk(v, exp, req);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk({31'd0, rx_ready}, 32'd1, "R4 reset ready");
        chk({31'd0, tx_valid}, 32'd0, "R2 reset tx_valid");
        chk({31'd0, irq}, 32'd0, "R10 reset irq");

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            bus(VEC[i][48], VEC[i][39:32], VEC[i][31:0], v);
            if (VEC[i][48]) chk(v, VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][47:40], i));
        end

        // R4 R5 fill, overflow, overrun flag
        chk({31'd0, irq}, 32'd0, "R10 idle irq");
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
        chk({31'd0, rx_ready}, 32'd0, "R4 full ready low");
        chk({31'd0, irq}, 32'd1, "R10 irq on data");
        rd_chk(8'h08, 32'h17, "R2 full status");
        push(8'h99);
        rd_chk(8'h08, 32'h37, "R5 overrun set");
        rd_chk(8'h08, 32'h17, "R5 overrun cleared, R9 pend kept");
        for (int i = 0; i < 8; i++) rd_chk(8'h00, 32'h10 + i, "R3 order after drop R4");
        rd_chk(8'h08, 32'h14, "R9 pend until read");
        rd_chk(8'h08, 32'h04, "R9 pend cleared");
        rd_chk(8'h00, 32'h0, "R3 empty read zero");
        rd_chk(8'h08, 32'h04, "R3 empty read no change");

        // R3 pointer wrap
        for (int i = 0; i < 5; i++) push(8'h20 + 8'(i));
        for (int i = 0; i < 3; i++) rd_chk(8'h00, 32'h20 + i, "R3 wrap first");
        for (int i = 5; i < 10; i++) push(8'h20 + 8'(i));
        for (int i = 3; i < 10; i++) rd_chk(8'h00, 32'h20 + i, "R3 wrap second");
        rd_chk(8'h08, 32'h14, "R9 after drain");

        // R6 flush
        for (int i = 0; i < 3; i++) push(8'h40 + 8'(i));
        wr(8'h0C, 32'h0000_0012);
        rd_chk(8'h0C, 32'h12, "R6 ctrl stored");
        rd_chk(8'h00, 32'h0, "R6 flushed");
        chk({31'd0, irq}, 32'd1, "R10 irq pend and enable");
        rd_chk(8'h08, 32'h14, "R6 status after flush");
        chk({31'd0, irq}, 32'd0, "R10 irq after clear");
        wr(8'h0C, 32'h0000_0002);
        push(8'h55);
        chk({31'd0, irq}, 32'd0, "R10 irq disabled");
        rd_chk(8'h08, 32'h15, "R10 pend without enable");
        rd_chk(8'h00, 32'h55, "R3 single byte");

        // R7 R8 transmit
        wr(8'h04, 32'h0000_003C);
        chk({31'd0, tx_valid}, 32'd1, "R7 tx valid");
        chk({24'd0, tx_data}, 32'h3C, "R7 tx data");
        wr(8'h04, 32'h0000_015D);
        chk({24'd0, tx_data}, 32'h5D, "R7 tx replace");
        tx_ready = 1'b1;
        @(posedge clk);
        #1 chk({31'd0, tx_valid}, 32'd0, "R7 tx taken");
        tx_ready = 1'b0;
        wr(8'h04, 32'h0000_0077);
        wr(8'h0C, 32'h0000_0001);
        chk({31'd0, tx_valid}, 32'd0, "R8 tx dropped");
        rd_chk(8'h08, 32'h14, "R8 status after drop");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule